// File: doc/BRIEF.md
# Mailbox and Doorbell Register Bank

This block is a small 64-bit register bank that a host processor and a service processor share for passing messages. It holds eight mailbox words and two doorbells. Mailbox words 0 to 3 carry commands from the host to the service side, and words 4 to 7 carry responses back. Every mailbox word is plain read/write storage.

The service doorbell tells the command engine that a message is waiting. Writing its message-waiting bit does not leave the bit set. The bit clears at once, and the block sends a one-cycle `proc_msg` strobe to the command engine. The host doorbell collects response and status flags. The command engine can set flags in it through `evt_set`, and it drives the level interrupt `host_irq`.

Each doorbell has three addresses: a direct write, a write of the old value ANDed with the data, and a write of the old value ORed with the data. The register port takes a doubleword word index, which is the byte address shifted right by 3, and supports only full 64-bit accesses. Reads are combinational.

Top module: `mbox_doorbell_bank`

## Requirements
- R1: Indices 0 to 7 are mailbox words. A write stores all 64 bits, and a read of the same index returns them from the clock edge after the write.
- R2: A write to an index not listed in R1, R3 or R6 changes no state. A read of any index other than 0 to 7, 0x10 or 0x13 returns zero. This includes the alias indices 0x11, 0x12, 0x14 and 0x15.
- R3: The host doorbell is written at three indices. Index 0x13 replaces it with the data. Index 0x14 replaces it with the old value AND the data. Index 0x15 replaces it with the old value OR the data. It is read back at index 0x13.
- R4: The host doorbell keeps only bits 63 to 59 and bit 49 (keep mask 0xF802_0000_0000_0000, LSB-0 numbering). Every other written or event bit reads back as 0.
- R5: `host_irq` is high exactly when the stored host doorbell is nonzero. It follows the stored value in the same cycle that the value changes.
- R6: The service doorbell is written at three indices: 0x10 direct, 0x11 AND, and 0x12 OR. Its only kept bit is bit 63. When the written value has bit 63 set, the bit clears at once and `proc_msg` is high for the single cycle after that write's clock edge. Index 0x10 therefore always reads 0, and an AND write can never fire the strobe.
- R7: `evt_set` is ORed into the host doorbell on every clock edge and then masked as in R4. When it coincides with a host doorbell write, the write is applied first and the event bits are ORed on top of the result.
- R8: Reset (active-low, asynchronous) clears all mailbox words and the host doorbell, and drives `host_irq` and `proc_msg` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one full doubleword |
| wr_idx | input | 5 | Word index of the write |
| wr_data | input | 64 | Write data |
| rd_idx | input | 5 | Word index of the combinational read |
| rd_data | output | 64 | Read data |
| evt_set | input | 64 | Command-engine set mask for the host doorbell |
| host_irq | output | 1 | Level interrupt, high while the host doorbell is nonzero |
| proc_msg | output | 1 | One-cycle strobe: a message is waiting for the command engine |

## Verification
Every write and event takes effect at the clock edge that samples it. One time unit after that edge, the bench expects three things: the new mailbox or doorbell contents on `rd_data` for the held read index, the matching `host_irq` level, and `proc_msg` high for exactly that one cycle. The reference model advances once per rising edge, using the inputs that edge sampled. All three outputs are compared with the model on every cycle, one time unit after the edge, while the inputs stay stable from the preceding falling edge. Reset is checked asynchronously, before any edge occurs.

// File: rtl/mbox_doorbell_bank.sv
module mbox_doorbell_bank #(
  parameter int          IDX_W     = 5,
  parameter int          N_MBOX    = 8,
  parameter int          MSG_BIT   = 63,
  parameter logic [63:0] HOST_KEEP = 64'hF802_0000_0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_data,
  input  logic [63:0]      evt_set,
  output logic             host_irq,
  output logic             proc_msg
);
  localparam int MB_AW = $clog2(N_MBOX);
  localparam logic [IDX_W-1:0] SVC_RW  = IDX_W'(16);
  localparam logic [IDX_W-1:0] SVC_AND = IDX_W'(17);
  localparam logic [IDX_W-1:0] SVC_OR  = IDX_W'(18);
  localparam logic [IDX_W-1:0] HST_RW  = IDX_W'(19);
  localparam logic [IDX_W-1:0] HST_AND = IDX_W'(20);
  localparam logic [IDX_W-1:0] HST_OR  = IDX_W'(21);
  localparam logic [IDX_W-1:0] MB_END  = IDX_W'(N_MBOX);

  logic [63:0] mbox [N_MBOX];
  logic [63:0] host_db, host_nx;
  logic        svc_fire;

  wire wr_mbox = wr_en && (wr_idx < MB_END);

  // service doorbell self-clears, so its held value is always zero
  assign svc_fire = wr_en && wr_data[MSG_BIT] &&
                    ((wr_idx == SVC_RW) || (wr_idx == SVC_OR));

  always_comb begin
    host_nx = host_db;
    if (wr_en) begin
      case (wr_idx)
        HST_RW:  host_nx = wr_data;
        HST_AND: host_nx = host_db & wr_data;
        HST_OR:  host_nx = host_db | wr_data;
        default: host_nx = host_db;
      endcase
    end
    host_nx = (host_nx | evt_set) & HOST_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_db  <= '0;
      proc_msg <= 1'b0;
      for (int i = 0; i < N_MBOX; i++) mbox[i] <= '0;
    end else begin
      host_db  <= host_nx;
      proc_msg <= svc_fire;
      if (wr_mbox) mbox[wr_idx[MB_AW-1:0]] <= wr_data;
    end
  end

  assign host_irq = |host_db;

  always_comb begin
    if (rd_idx < MB_END)       rd_data = mbox[rd_idx[MB_AW-1:0]];
    else if (rd_idx == HST_RW) rd_data = host_db;
    else                       rd_data = '0;
  end

  p_mbox_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mbox |=> mbox[$past(wr_idx[MB_AW-1:0])] == $past(wr_data));

  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[MSG_BIT] && (wr_idx == SVC_OR)) |=> proc_msg);

  p_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (wr_idx == SVC_AND)) |=> !proc_msg);

  p_evt_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & HOST_KEEP) != 0) |=> host_irq);

  p_and_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == HST_AND) && (wr_data == 64'd0) && (evt_set == 64'd0))
      |=> !host_irq);
endmodule

// File: tb/mbox_doorbell_bank_test.sv
`timescale 1ns/1ps
module mbox_doorbell_bank_test;
  localparam logic [63:0] KEEP = 64'hF802_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic [63:0] evt_set = '0;
  logic        host_irq, proc_msg;

  always #2.5 clk = ~clk;

  mbox_doorbell_bank uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .evt_set(evt_set),
    .host_irq(host_irq), .proc_msg(proc_msg));

  logic [63:0] m_mb [8];
  logic [63:0] m_host;
  bit          m_proc;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [63:0] m_read(input logic [4:0] i);
    if (i < 8) return m_mb[i[2:0]];
    if (i == 5'h13) return m_host;
    return 64'd0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "rd_data", rd_data, m_read(rd_idx));
    chk("R5", "host_irq", {63'd0, host_irq}, {63'd0, m_host != 0});
    chk("R6", "proc_msg", {63'd0, proc_msg}, {63'd0, m_proc});
  endtask

  task automatic step(input bit we, input logic [4:0] idx, input logic [63:0] d,
                      input logic [63:0] ev, input logic [4:0] ridx, input string tag);
    @(negedge clk);
    wr_en = we; wr_idx = idx; wr_data = d; evt_set = ev; rd_idx = ridx;
    @(posedge clk);
    m_proc = 0;
    if (we) begin
      if (idx < 8) m_mb[idx[2:0]] = d;
      else if ((idx == 5'h10 || idx == 5'h12) && d[63]) m_proc = 1;
      else if (idx == 5'h13) m_host = d;
      else if (idx == 5'h14) m_host = m_host & d;
      else if (idx == 5'h15) m_host = m_host | d;
    end
    m_host = (m_host | ev) & KEEP;
    #1;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; evt_set = '0;
    foreach (m_mb[i]) m_mb[i] = '0;
    m_host = '0; m_proc = 0;
    #1;
    for (int i = 0; i < 8; i++) begin
      rd_idx = 5'(i); #0.1;
      chk("R8", "reset mailbox", rd_data, 64'd0);
    end
    rd_idx = 5'h13; #0.1;
    compare("R8");
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    foreach (m_mb[i]) m_mb[i] = '0;
    m_host = '0; m_proc = 0;
    do_reset();
    // R1: mailbox patterns
    for (int i = 0; i < 8; i++)
      step(1, 5'(i), {32'hA5A5_0000 + 32'(i), 32'h1234_5678 ^ 32'(i * 7)}, 0, 5'(i), "R1");
    step(1, 5'd7, 64'hFFFF_FFFF_FFFF_FFFF, 0, 5'd7, "R1");
    step(1, 5'd0, 64'h0, 0, 5'd0, "R1");
    for (int i = 0; i < 8; i++) step(0, 5'd0, 64'hDEAD, 0, 5'(i), "R1");
    // R2: unmapped writes ignored, aliases read zero
    step(1, 5'h08, 64'hFFFF_FFFF_FFFF_FFFF, 0, 5'd1, "R2");
    step(1, 5'h17, 64'hFFFF_FFFF_FFFF_FFFF, 0, 5'd2, "R2");
    step(1, 5'h1F, 64'hFFFF_FFFF_FFFF_FFFF, 0, 5'h13, "R2");
    step(0, 5'd0, 0, 0, 5'h1F, "R2");
    step(0, 5'd0, 0, 0, 5'h08, "R2");
    // R4, R3: host doorbell direct / AND / OR
    step(1, 5'h13, 64'hFFFF_FFFF_FFFF_FFFF, 0, 5'h13, "R4");
    step(0, 5'd0, 0, 0, 5'h14, "R2");
    step(0, 5'd0, 0, 0, 5'h15, "R2");
    step(1, 5'h14, 64'h0802_0000_0000_0000, 0, 5'h13, "R3");
    step(1, 5'h15, 64'h8000_0000_0000_0001, 0, 5'h13, "R3");
    step(1, 5'h14, 64'h0, 0, 5'h13, "R3");
    step(1, 5'h13, 64'h07FD_FFFF_FFFF_FFFF, 0, 5'h13, "R4");
    step(1, 5'h13, 64'h0002_0000_0000_0000, 0, 5'h13, "R5");
    step(1, 5'h13, 64'h0, 0, 5'h13, "R5");
    // R6: service doorbell
    step(1, 5'h10, 64'h8000_0000_0000_0000, 0, 5'h10, "R6");
    step(0, 5'd0, 0, 0, 5'h10, "R6");
    step(1, 5'h11, 64'hFFFF_FFFF_FFFF_FFFF, 0, 5'h10, "R6");
    step(1, 5'h12, 64'h8000_0000_0000_0000, 0, 5'h10, "R6");
    step(1, 5'h12, 64'h8000_0000_0000_0000, 0, 5'h11, "R6");
    step(1, 5'h10, 64'h7FFF_FFFF_FFFF_FFFF, 0, 5'h10, "R6");
    step(1, 5'h12, 64'h0, 0, 5'h12, "R6");
    // R7: events
    step(0, 5'd0, 0, 64'h0000_0000_FFFF_FFFF, 5'h13, "R7");
    step(0, 5'd0, 0, 64'h4000_0000_0000_0000, 5'h13, "R7");
    step(1, 5'h13, 64'h8000_0000_0000_0000, 64'h0002_0000_0000_0000, 5'h13, "R7");
    step(1, 5'h14, 64'h0, 64'h1000_0000_0000_0000, 5'h13, "R7");
    step(1, 5'h13, 64'h0, 64'h0, 5'h13, "R7");
    // R8: reset mid-run
    step(1, 5'd3, 64'h0123_4567_89AB_CDEF, 64'hF800_0000_0000_0000, 5'd3, "R1");
    do_reset();
    step(0, 5'd0, 0, 0, 5'd3, "R8");
    step(0, 5'd0, 0, 0, 5'h13, "R8");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule